// File: doc/BRIEF.md
# MIDI UART Receive/Transmit Port

This block is the byte-level MIDI port of a register-mapped audio controller. Software reaches it through three byte registers: a 6-bit control word, a data port and a shared status byte. Bytes coming in from the serial side arrive on a valid/byte pair and are stored in a 16-entry circular receive queue. A data read pops the queue. A data write is passed to a one-cycle transmit strobe.

A periodic tick refreshes the "transmit ready" and "activity" status flags. Three timer event inputs from neighbouring logic set their own status flags. A single interrupt line is asserted for every pending status flag whose mask bit is clear. The MIDI mask bits come from an external interrupt-mask register and the timer mask bits come from a separate input.

Register select: 0 selects control, 1 selects data, 2 selects status, and 3 reads as zero. Read data is registered and appears the cycle after the read strobe. Status bit positions: 0x04 is receive pending, 0x08 is transmit ready, 0x10/0x20/0x40 are timers 0/1/2, and 0x80 is activity. Bits 0x01 and 0x02 always read 0.

Top module: `midi_port_ctl`

## Requirements
- R1: A control write keeps only bits [5:0]. A control read returns them with bits [7:6] zero. Select 3 reads as 0. Read data is valid the cycle after the read strobe.
- R2: A control write whose low nibble is 0000 turns receive and transmit off, returns both queue pointers to entry 0, and clears status 0x80, 0x08 and 0x04.
- R3: A control write whose low nibble is 1111 clears status 0x80, 0x08 and 0x04 and leaves the enables and the queue untouched.
- R4: Any other low nibble clears status 0x80 and applies its bits as follows. Bit0 turns receive on and bit2 turns transmit on. Bit1 turns receive off and empties the queue. Bit3 turns transmit off. A disable bit beats an enable bit in the same write.
- R5: The queue holds 16 bytes and both pointers wrap modulo 16. Nothing protects against overrun: after 17 pushes into an empty queue, the first entry holds the 17th byte and the queue looks one entry full.
- R6: A data read with receive on returns the entry at the read pointer and clears status 0x04. The pointer advances only when it differs from the write pointer. With receive off, a data read returns 0 and changes nothing.
- R7: A data write with transmit on gives tx_strobe high for one cycle, with the byte on tx_byte on the next cycle, and clears status 0x08. With transmit off, the write is ignored.
- R8: A tick sets status 0x08 if transmit is on, and sets 0x80 if control bit4 is 1. This happens only when the control word is neither 0x00 nor 0x3F.
- R9: An arriving byte is stored and sets status 0x04 only while receive is on.
- R10: irq is high when 0x04 is set with irq_mask[0]=0, or 0x08 is set with irq_mask[2]=0, or 0x80 is set with irq_mask[4]=0.
- R11: A pulse on tmr_evt[k] sets status bit 4+k. irq is also high while status bit 4+k is set and tmr_mask[k]=0.
- R12: A status read returns the status byte and then clears bits 0xF3, keeping 0x04 and 0x08.
- R13: In the same cycle, any set beats any clear: byte arrival beats a data read, tick beats a status read, and a timer pulse beats a status read. A control write suppresses byte storage and tick sets in its own cycle.
- R14: After reset, status, control, enables, pointers, read data, tx_strobe and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored when wr_en is high) |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rx_valid | input | 1 | Incoming MIDI byte valid |
| rx_byte | input | 8 | Incoming MIDI byte |
| tx_strobe | output | 1 | Outgoing byte valid, one cycle |
| tx_byte | output | 8 | Outgoing byte |
| tick | input | 1 | Periodic status refresh pulse |
| tmr_evt | input | 3 | Timer event pulses |
| irq_mask | input | 8 | MIDI interrupt mask bits (bits 0, 2, 4 used) |
| tmr_mask | input | 3 | Timer interrupt mask bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The collision that matters most is a byte arriving in the same cycle as a data read. The read must return the entry taken at the old read pointer. The pointer comparison must use the write pointer from before the push. Status 0x04 must remain set because the new byte wins.

The bench forces this collision directly, once with the queue empty and once with it holding data. It also forces a tick against a status read and a control write against a byte arrival. Random traffic then makes all these cycles overlap freely. Every read value, every transmit strobe and the interrupt line are compared each cycle against a bench model built from the requirements.

// File: rtl/midi_port_pkg.sv
// Shared constants and types for the MIDI port.
// Assumes an 8-bit status byte whose bit positions are fixed by software.
package midi_port_pkg;
    localparam int ST_W      = 8;
    localparam int ST_RXPEND = 2;
    localparam int ST_TXRDY  = 3;
    localparam int ST_TMR0   = 4;
    localparam int ST_ACT    = 7;
    localparam int N_TMR     = 3;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // Effect of one control write
    typedef struct packed {
        logic            rx_on;
        logic            tx_on;
        logic            flush;
        logic [ST_W-1:0] clr;
    } ctrl_act_t;
endpackage

// File: rtl/midi_ctrl_decode.sv
// Decodes the low nibble of a control write into next enables, queue flush
// and the status bits to clear. Purely combinational; assumes the caller
// applies the result only on a control write.
module midi_ctrl_decode
    import midi_port_pkg::*;
(
    input  logic [3:0] nib,
    input  logic       rx_on,
    input  logic       tx_on,
    output ctrl_act_t  act
);
    // Nibble decode with the two special codes first, disables after enables
    always_comb begin
        act.rx_on = rx_on;
        act.tx_on = tx_on;
        act.flush = 1'b0;
        act.clr   = '0;
        if (nib == 4'h0) begin
            act.rx_on = 1'b0;
            act.tx_on = 1'b0;
            act.flush = 1'b1;
            act.clr   = 8'h8C;
        end else if (nib == 4'hF) begin
            act.clr   = 8'h8C;
        end else begin
            if (nib[0]) act.rx_on = 1'b1;
            if (nib[2]) act.tx_on = 1'b1;
            if (nib[1]) begin
                act.rx_on = 1'b0;
                act.flush = 1'b1;
            end
            if (nib[3]) act.tx_on = 1'b0;
            act.clr = 8'h80;
        end
    end

    // R4
    always_comb begin
        flush_stops_rx_chk: assert (!(act.flush && act.rx_on));
    end
endmodule

// File: rtl/midi_rx_queue.sv
// Circular receive queue. Pointers wrap by natural overflow, so DEPTH must
// be a power of two. No overrun protection: a push always writes and advances.
module midi_rx_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Storage and pointer update; flush overrides both pointer moves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) mem[wr_ptr] <= din;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push) wr_ptr <= wr_ptr + 1'b1;
                if (pop && (rd_ptr != wr_ptr)) rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    assign dout = mem[rd_ptr];

    // R2
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wr_ptr == '0 && rd_ptr == '0));
    // R6
    pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && rd_ptr == wr_ptr) |=> $stable(rd_ptr));
endmodule

// File: rtl/midi_status_irq.sv
// Status byte and combined interrupt. Each cycle the clears from register
// accesses are applied first and the sets from events last, so sets win.
// Assumes at most one register access per cycle.
module midi_status_irq
    import midi_port_pkg::*;
#(
    parameter int CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [ST_W-1:0]   ctrl_clr,
    input  logic              st_read,
    input  logic              rx_take,
    input  logic              tx_send,
    input  logic              rx_push,
    input  logic              tick,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic              tx_on,
    input  logic [N_TMR-1:0]  tmr_evt,
    input  logic [ST_W-1:0]   irq_mask,
    input  logic [N_TMR-1:0]  tmr_mask,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    logic [ST_W-1:0] clr;
    logic [ST_W-1:0] set;
    logic            tick_live;
    logic            unused_mask_bits;

    assign unused_mask_bits = ^{irq_mask[7:5], irq_mask[3], irq_mask[1]};
    assign tick_live = tick && !ctrl_wr && (ctrl_q != '0) && (ctrl_q != '1);

    // Gather the clear and set masks for this cycle
    always_comb begin
        clr = ctrl_wr ? ctrl_clr : '0;
        if (st_read) clr = clr | 8'hF3;
        if (rx_take) clr[ST_RXPEND] = 1'b1;
        if (tx_send) clr[ST_TXRDY]  = 1'b1;
        set = '0;
        set[ST_RXPEND] = rx_push;
        set[ST_TXRDY]  = tick_live && tx_on;
        set[ST_ACT]    = tick_live && ctrl_q[4];
        set[ST_TMR0 +: N_TMR] = tmr_evt;
    end

    // Status register: clear, then set
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set;
    end

    // Interrupt from every unmasked pending flag
    always_comb begin
        irq = (status[ST_RXPEND] && !irq_mask[0]) ||
              (status[ST_TXRDY]  && !irq_mask[2]) ||
              (status[ST_ACT]    && !irq_mask[4]) ||
              (|(status[ST_TMR0 +: N_TMR] & ~tmr_mask));
    end

    // R12
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_read && !tick && tmr_evt == '0) |=> (status[7:4] == 4'h0));
    // R12
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_read && !rx_take && !tx_send && !ctrl_wr)
        |=> ((status[3:2] & $past(status[3:2])) == $past(status[3:2])));
    // R9
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> status[ST_RXPEND]);
endmodule

// File: rtl/midi_port_ctl.sv
// MIDI port top: register decode, control/enable state, registered read
// mux and transmit strobe. Assumes wr_en and rd_en are single-cycle strobes
// and that a write in the same cycle as a read suppresses the read.
module midi_port_ctl
    import midi_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int QDEPTH = 16,
    parameter int CTRL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_strobe,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic [N_TMR-1:0]  tmr_evt,
    input  logic [ST_W-1:0]   irq_mask,
    input  logic [N_TMR-1:0]  tmr_mask,
    output logic              irq
);
    sel_e              sel;
    logic              rd_any;
    logic              ctrl_wr, data_wr, data_rd, st_rd;
    logic              rx_push, rx_take, tx_send;
    logic [CTRL_W-1:0] ctrl_q;
    logic              rx_on, tx_on;
    ctrl_act_t         act;
    logic [DATA_W-1:0] q_dout;
    logic [ST_W-1:0]   status;

    assign sel     = sel_e'(reg_sel);
    assign rd_any  = rd_en && !wr_en;
    assign ctrl_wr = wr_en && sel == SEL_CTRL;
    assign data_wr = wr_en && sel == SEL_DATA;
    assign data_rd = rd_any && sel == SEL_DATA;
    assign st_rd   = rd_any && sel == SEL_STAT;
    assign rx_push = rx_valid && rx_on && !ctrl_wr;
    assign rx_take = data_rd && rx_on;
    assign tx_send = data_wr && tx_on;

    midi_ctrl_decode u_dec (
        .nib   (wr_data[3:0]),
        .rx_on (rx_on),
        .tx_on (tx_on),
        .act   (act)
    );

    midi_rx_queue #(.DEPTH(QDEPTH), .DATA_W(DATA_W)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .pop   (rx_take),
        .flush (ctrl_wr && act.flush),
        .din   (rx_byte),
        .dout  (q_dout)
    );

    midi_status_irq #(.CTRL_W(CTRL_W)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_clr (act.clr),
        .st_read  (st_rd),
        .rx_take  (rx_take),
        .tx_send  (tx_send),
        .rx_push  (rx_push),
        .tick     (tick),
        .ctrl_q   (ctrl_q),
        .tx_on    (tx_on),
        .tmr_evt  (tmr_evt),
        .irq_mask (irq_mask),
        .tmr_mask (tmr_mask),
        .status   (status),
        .irq      (irq)
    );

    // Control word and enable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rx_on  <= 1'b0;
            tx_on  <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
            rx_on  <= act.rx_on;
            tx_on  <= act.tx_on;
        end
    end

    // Registered read mux; holds its value between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_any) begin
            case (sel)
                SEL_CTRL: rd_data <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                SEL_DATA: rd_data <= rx_on ? q_dout : '0;
                SEL_STAT: rd_data <= status;
                default:  rd_data <= '0;
            endcase
        end
    end

    // Transmit strobe and byte, one cycle after an accepted data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_strobe <= tx_send;
            if (tx_send) tx_byte <= wr_data;
        end
    end

    // R7
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(tx_on));
    // R2
    full_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[3:0] == 4'h0) |=> (!rx_on && !tx_on));
    // R6
    rd_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_on) |=> (rd_data == '0));
endmodule

// File: tb/midi_port_ctl_test.sv
module midi_port_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en, rx_valid, tick;
    logic [1:0] reg_sel;
    logic [7:0] wr_data, rx_byte, irq_mask;
    logic [2:0] tmr_evt, tmr_mask;
    logic [7:0] rd_data, tx_byte;
    logic       tx_strobe, irq;

    always #10 clk = ~clk;

    midi_port_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .tick(tick), .tmr_evt(tmr_evt),
        .irq_mask(irq_mask), .tmr_mask(tmr_mask), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    // Bench model of the port state
    logic [5:0] m_ctrl;
    bit         m_rx, m_tx;
    logic [7:0] m_st;
    logic [7:0] m_mem [16];
    logic [3:0] m_wr, m_rd;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit irq_exp();
        return (m_st[2] && !irq_mask[0]) || (m_st[3] && !irq_mask[2]) ||
               (m_st[7] && !irq_mask[4]) || (|(m_st[6:4] & ~tmr_mask));
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_rx = 0; m_tx = 0; m_st = '0; m_wr = '0; m_rd = '0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
    endtask

    // One clock: drive at the falling edge, predict, check at the next one
    task automatic cyc(string tag, bit w, bit r, logic [1:0] a, logic [7:0] d,
                       bit rv, logic [7:0] rb, bit tk, logic [2:0] te);
        logic [7:0] exp_rd, clr, set;
        logic [3:0] nib;
        bit exp_tx, cw;
        wr_en = w; rd_en = r; reg_sel = a; wr_data = d;
        rx_valid = rv; rx_byte = rb; tick = tk; tmr_evt = te;
        exp_rd = '0; clr = '0; set = '0; exp_tx = 0;
        cw = w && a == 2'd0;
        if (r && !w) begin
            case (a)
                2'd0: exp_rd = {2'b00, m_ctrl};
                2'd1: exp_rd = m_rx ? m_mem[m_rd] : 8'h00;
                2'd2: exp_rd = m_st;
                default: exp_rd = 8'h00;
            endcase
            if (a == 2'd1 && m_rx) begin
                clr[2] = 1'b1;
                if (m_rd != m_wr) m_rd++;
            end
            if (a == 2'd2) clr = clr | 8'hF3;
        end
        if (w && a == 2'd1 && m_tx) begin
            exp_tx = 1;
            clr[3] = 1'b1;
        end
        if (!cw) begin
            if (rv && m_rx) begin
                m_mem[m_wr] = rb;
                m_wr++;
                set[2] = 1'b1;
            end
            if (tk && m_ctrl != 6'h00 && m_ctrl != 6'h3F) begin
                if (m_tx) set[3] = 1'b1;
                if (m_ctrl[4]) set[7] = 1'b1;
            end
        end else begin
            nib = d[3:0];
            m_ctrl = d[5:0];
            if (nib == 4'h0) begin
                m_rx = 0; m_tx = 0; m_wr = '0; m_rd = '0; clr = clr | 8'h8C;
            end else if (nib == 4'hF) begin
                clr = clr | 8'h8C;
            end else begin
                if (nib[0]) m_rx = 1;
                if (nib[2]) m_tx = 1;
                if (nib[1]) begin m_rx = 0; m_wr = '0; m_rd = '0; end
                if (nib[3]) m_tx = 0;
                clr = clr | 8'h80;
            end
        end
        set[6:4] = te;
        m_st = (m_st & ~clr) | set;
        @(posedge clk);
        @(negedge clk);
        if (r && !w) chk(tag, "read data", rd_data, exp_rd);
        chk(tag, "tx_strobe", tx_strobe, exp_tx);
        if (exp_tx) chk(tag, "tx_byte", tx_byte, d);
        chk(tag, "irq", irq, irq_exp());
        wr_en = 0; rd_en = 0; rx_valid = 0; tick = 0; tmr_evt = '0;
    endtask

    task automatic wctl(string tag, logic [7:0] v);
        cyc(tag, 1, 0, 2'd0, v, 0, 8'h00, 0, 3'b000);
    endtask
    task automatic rd(string tag, logic [1:0] a);
        cyc(tag, 0, 1, a, 8'h00, 0, 8'h00, 0, 3'b000);
    endtask
    task automatic push(string tag, logic [7:0] b);
        cyc(tag, 0, 0, 2'd0, 8'h00, 1, b, 0, 3'b000);
    endtask
    task automatic tk1(string tag);
        cyc(tag, 0, 0, 2'd0, 8'h00, 0, 8'h00, 1, 3'b000);
    endtask

    bit done = 0;

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        rst_n = 0; wr_en = 0; rd_en = 0; reg_sel = '0; wr_data = '0;
        rx_valid = 0; rx_byte = '0; tick = 0; tmr_evt = '0;
        irq_mask = 8'h00; tmr_mask = 3'b000;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R14 reset state
        chk("R14", "rd_data", rd_data, 8'h00);
        chk("R14", "tx_strobe", tx_strobe, 1'b0);
        chk("R14", "irq", irq, 1'b0);
        rd("R14", 2'd0);
        rd("R14", 2'd2);
        rd("R6", 2'd1);
        // R1 low six bits kept, select 3 reads zero
        wctl("R1", 8'h3D);
        rd("R1", 2'd0);
        wctl("R1", 8'hC5);
        rd("R1", 2'd0);
        rd("R1", 2'd3);
        // R9 store and read back
        push("R9", 8'hA1);
        rd("R12", 2'd2);
        rd("R6", 2'd1);
        rd("R6", 2'd1);
        // R9 receive off drops bytes, R4 bit1 flush
        wctl("R4", 8'h02);
        push("R9", 8'h55);
        rd("R9", 2'd1);
        rd("R9", 2'd2);
        // R5 overrun wrap: 17 bytes into an empty queue
        wctl("R2", 8'h00);
        wctl("R4", 8'h05);
        for (int i = 0; i < 17; i++) push("R5", 8'(8'h40 + i));
        rd("R5", 2'd1);
        rd("R5", 2'd1);
        rd("R5", 2'd1);
        // R7 transmit on and off
        cyc("R7", 1, 0, 2'd1, 8'h90, 0, 8'h00, 0, 3'b000);
        wctl("R4", 8'h08);
        cyc("R7", 1, 0, 2'd1, 8'h91, 0, 8'h00, 0, 3'b000);
        wctl("R4", 8'h04);
        cyc("R7", 1, 0, 2'd1, 8'h92, 0, 8'h00, 0, 3'b000);
        // R8 tick sets, and no set at 0x3F
        wctl("R8", 8'h15);
        tk1("R8");
        rd("R8", 2'd2);
        wctl("R8", 8'h3F);
        tk1("R8");
        rd("R8", 2'd2);
        // R3 nibble 1111 clears status only
        wctl("R3", 8'h15);
        tk1("R3");
        push("R3", 8'h77);
        wctl("R3", 8'h1F);
        rd("R3", 2'd2);
        rd("R3", 2'd0);
        rd("R3", 2'd1);
        // R10 masking
        wctl("R10", 8'h15);
        tk1("R10");
        push("R10", 8'h12);
        irq_mask = 8'h15;
        cyc("R10", 0, 0, 2'd0, 8'h00, 0, 8'h00, 0, 3'b000);
        irq_mask = 8'h11;
        cyc("R10", 0, 0, 2'd0, 8'h00, 0, 8'h00, 0, 3'b000);
        irq_mask = 8'h05;
        cyc("R10", 0, 0, 2'd0, 8'h00, 0, 8'h00, 0, 3'b000);
        // R11 timer flags
        irq_mask = 8'h15;
        tmr_mask = 3'b101;
        cyc("R11", 0, 0, 2'd0, 8'h00, 0, 8'h00, 0, 3'b101);
        tmr_mask = 3'b001;
        cyc("R11", 0, 0, 2'd0, 8'h00, 0, 8'h00, 0, 3'b000);
        // R12 status read clears upper bits, keeps 0x0C
        rd("R12", 2'd2);
        rd("R12", 2'd2);
        irq_mask = 8'h00; tmr_mask = 3'b000;
        // R13 collisions
        wctl("R13", 8'h00);
        wctl("R13", 8'h15);
        cyc("R13", 0, 1, 2'd1, 8'h00, 1, 8'hB0, 0, 3'b000);
        cyc("R13", 0, 1, 2'd1, 8'h00, 1, 8'hB1, 0, 3'b000);
        rd("R13", 2'd2);
        cyc("R13", 0, 1, 2'd2, 8'h00, 0, 8'h00, 1, 3'b010);
        rd("R13", 2'd2);
        cyc("R13", 1, 0, 2'd0, 8'h15, 1, 8'hEE, 1, 3'b000);
        rd("R13", 2'd1);
        rd("R13", 2'd2);
        // Random traffic mixed with the directed values above
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [7:0] cv;
            op = int'($urandom % 16);
            case ($urandom % 8)
                0: cv = 8'h00; 1: cv = 8'h0F; 2: cv = 8'h3F; 3: cv = 8'h15;
                4: cv = 8'h05; 5: cv = 8'h02; 6: cv = 8'h1D;
                default: cv = 8'($urandom);
            endcase
            if (($urandom % 64) == 0) irq_mask = 8'($urandom);
            if (($urandom % 64) == 0) tmr_mask = 3'($urandom);
            cyc("R13", op == 0, op inside {[1:6]}, op == 0 ? 2'd0 : 2'($urandom % 4),
                cv, ($urandom % 3) == 0, 8'($urandom), ($urandom % 4) == 0,
                (($urandom % 8) == 0) ? 3'($urandom) : 3'b000);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule